// File: doc/BRIEF.md
# Programmable Display Timing Generator with Sub-Window

This block turns a free-running pixel clock into the sync, data-enable and pixel stream for a display panel. Software sets the line length, the frame length and every window edge through a simple word-indexed write port, then turns the generator on. Horizontal positions are pixel offsets inside a line. Vertical positions are absolute pixel-clock counts inside the frame, so a line-level edge can be moved by a few clocks to add an hsync skew.

Inside the display window the block can place a smaller active window, which has its own enable. Display pixels outside that window get a fixed border color. Pixels inside it are requested from an upstream source through `pixReq`. If the source cannot supply a pixel when one is requested, an underflow color is sent instead. With recovery enabled, the underflow color is held for every source pixel until the frame ends. The sync and data-enable outputs each have their own polarity.

Top module: `vtg_top`

## Requirements
- R1: After reset, and one clock after the run bit (index 0, bit 0) is cleared, `frameStart`, `pixReq` and `pixOut` are zero and the sync and data-enable outputs rest at their inactive levels. The counters then restart at zero.
- R2: Setting the run bit starts the frame at count 0. `frameStart` is high for one clock once per frame, in the output cycle of count 0, and this includes the first frame. The frame count wraps after the frame length (index 4, in pixel clocks) and the line count wraps after the line length (index 3, bits 31:16).
- R3: The logical hsync is high while the line count c satisfies skew <= c < skew + pulse. The skew is at index 2 and the pulse width is at index 3, bits 15:0.
- R4: The logical vsync is high while the frame count is below the vsync width at index 5, which is given in pixel clocks.
- R5: The logical data enable is high when the line count lies within the display horizontal start and end, inclusive (index 6: end in bits 30:16, start in bits 14:0). The frame count must also lie within the display vertical start (index 7) and end (index 8), inclusive. Outside this window `pixOut` is zero.
- R6: When both sub-window enables are set (bit 31 of index 9 and bit 31 of index 10), the active window covers line counts from start to end (index 9, same field layout as index 6) and frame counts from index 10 bits 30:0 to index 11. Inside it the source pixel is sent. Display pixels outside it carry the border color at index 13.
- R7: When either sub-window enable is clear, the whole display window carries source pixels.
- R8: Underflow occurs when `pixReq` is high and `pixValid` is low. On an underflow the underflow color (index 12, low bits) replaces that pixel. With recovery off (index 12, bit 31 clear), the next pixel is normal again.
- R9: With recovery on, after an underflow every remaining source pixel of the frame carries the underflow color, while border pixels keep the border color. Normal pixels resume from the next frame.
- R10: The polarity word at index 1 inverts hsync (bit 0), vsync (bit 1) and data enable (bit 2) when the bit is 1. A value of 0 makes the signal active high.
- R11: All outputs are registered. The output for counter position n appears one clock after the counter holds n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word index |
| regWrData | input | 32 | Register write data |
| pixIn | input | COLOR_W | Pixel from the source |
| pixValid | input | 1 | Source pixel is available this clock |
| pixReq | output | 1 | A source pixel is consumed this clock |
| hsyncOut | output | 1 | Horizontal sync, polarity applied |
| vsyncOut | output | 1 | Vertical sync, polarity applied |
| deOut | output | 1 | Data enable, polarity applied |
| pixOut | output | COLOR_W | Pixel color |
| frameStart | output | 1 | One-clock pulse at the start of each frame |

## Verification
The bench builds the block with its default parameters: 15-bit line fields, a 24-bit frame counter and 24-bit color. It programs a 10-clock line and a 70-clock frame. Within a few hundred clocks this covers every window edge, both sync pulses and the frame wrap, and it leaves room for a restart after each mode change. Because the line is so short, a skew of a few clocks moves the hsync pulse by an amount that is easy to see. The underflow tests starve single chosen clocks and then check the pixels before and after them, plus the same position one frame later.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [3:0] {
    IDX_RUN    = 4'd0,
    IDX_POL    = 4'd1,
    IDX_SKEW   = 4'd2,
    IDX_LINE   = 4'd3,
    IDX_FRAME  = 4'd4,
    IDX_VWIDTH = 4'd5,
    IDX_DISPH  = 4'd6,
    IDX_DISPV0 = 4'd7,
    IDX_DISPV1 = 4'd8,
    IDX_WINH   = 4'd9,
    IDX_WINV0  = 4'd10,
    IDX_WINV1  = 4'd11,
    IDX_UFL    = 4'd12,
    IDX_BORDER = 4'd13
  } regIdx_e;

  localparam int NUM_REGS = 14;

  typedef struct packed {
    logic run;
    logic hsync;
    logic vsync;
    logic inDisp;
    logic outsideWin;
    logic pixReq;
    logic frameStart;
  } strobe_t;
endpackage

// File: rtl/vtg_regfile.sv
module vtg_regfile
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regWords [NUM_REGS]
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regWords[i] <= '0;
      else if (regWe && (regAddr == ADDR_W'(i))) regWords[i] <= regWrData;
    end
  end
endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int H_W = 15,
  parameter int F_W = 24
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           runEn,
  input  logic [H_W-1:0] lineLen,
  input  logic [H_W-1:0] hPulse,
  input  logic [H_W-1:0] skew,
  input  logic [F_W-1:0] frameLen,
  input  logic [F_W-1:0] vWidth,
  input  logic [H_W-1:0] dispHs,
  input  logic [H_W-1:0] dispHe,
  input  logic [F_W-1:0] dispVs,
  input  logic [F_W-1:0] dispVe,
  input  logic           winEn,
  input  logic [H_W-1:0] winHs,
  input  logic [H_W-1:0] winHe,
  input  logic [F_W-1:0] winVs,
  input  logic [F_W-1:0] winVe,
  output strobe_t        strb
);
  localparam int HX_W = H_W + 1;
  localparam int FX_W = F_W + 1;

  logic [H_W-1:0] lineCnt;
  logic [F_W-1:0] frameCnt;
  logic           frameWrap;
  logic           lineWrap;
  logic           inDispH, inDispV, inWinH, inWinV, inWin;
  logic [HX_W-1:0] hsEnd;

  assign frameWrap = (FX_W'(frameCnt) + FX_W'(1)) >= FX_W'(frameLen);
  assign lineWrap  = (HX_W'(lineCnt) + HX_W'(1)) >= HX_W'(lineLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt  <= '0;
      frameCnt <= '0;
    end else if (!runEn) begin
      lineCnt  <= '0;
      frameCnt <= '0;
    end else if (frameWrap) begin
      lineCnt  <= '0;
      frameCnt <= '0;
    end else begin
      frameCnt <= frameCnt + F_W'(1);
      lineCnt  <= lineWrap ? '0 : lineCnt + H_W'(1);
    end
  end

  assign hsEnd   = HX_W'(skew) + HX_W'(hPulse);
  assign inDispH = (lineCnt >= dispHs) && (lineCnt <= dispHe);
  assign inDispV = (frameCnt >= dispVs) && (frameCnt <= dispVe);
  assign inWinH  = (lineCnt >= winHs) && (lineCnt <= winHe);
  assign inWinV  = (frameCnt >= winVs) && (frameCnt <= winVe);
  assign inWin   = inWinH && inWinV;

  always_comb begin
    strb            = '0;
    strb.run        = runEn;
    strb.hsync      = runEn && (lineCnt >= skew) && (HX_W'(lineCnt) < hsEnd);
    strb.vsync      = runEn && (frameCnt < vWidth);
    strb.inDisp     = runEn && inDispH && inDispV;
    strb.outsideWin = runEn && inDispH && inDispV && winEn && !inWin;
    strb.pixReq     = runEn && inDispH && inDispV && (!winEn || inWin);
    strb.frameStart = runEn && (frameCnt == '0);
  end
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [COLOR_W-1:0] pixIn,
  input  logic               pixValid,
  input  logic [COLOR_W-1:0] borderColor,
  input  logic [COLOR_W-1:0] uflColor,
  input  logic               recoverEn,
  input  logic [2:0]         polBits,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic [COLOR_W-1:0] pixOut,
  output logic               frameStart
);
  logic               ufSticky;
  logic               starved;
  logic [COLOR_W-1:0] nextPix;

  assign starved = strb.pixReq && !pixValid;

  always_comb begin
    if (!strb.inDisp)             nextPix = '0;
    else if (strb.outsideWin)     nextPix = borderColor;
    else if (starved || ufSticky) nextPix = uflColor;
    else                          nextPix = pixIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ufSticky <= 1'b0;
    end else if (!strb.run) begin
      ufSticky <= 1'b0;
    end else if (starved && recoverEn) begin
      ufSticky <= 1'b1;
    end else if (strb.frameStart) begin
      ufSticky <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncOut   <= 1'b0;
      vsyncOut   <= 1'b0;
      deOut      <= 1'b0;
      pixOut     <= '0;
      frameStart <= 1'b0;
    end else begin
      hsyncOut   <= strb.hsync ^ polBits[0];
      vsyncOut   <= strb.vsync ^ polBits[1];
      deOut      <= strb.inDisp ^ polBits[2];
      pixOut     <= nextPix;
      frameStart <= strb.frameStart;
    end
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int H_W     = 15,
  parameter int F_W     = 24,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [3:0]         regAddr,
  input  logic [31:0]        regWrData,
  input  logic [COLOR_W-1:0] pixIn,
  input  logic               pixValid,
  output logic               pixReq,
  output logic               hsyncOut,
  output logic               vsyncOut,
  output logic               deOut,
  output logic [COLOR_W-1:0] pixOut,
  output logic               frameStart
);
  localparam int HI_LSB = 16;
  localparam int EN_BIT = 31;

  logic [31:0] regWords [NUM_REGS];
  strobe_t     strb;
  logic        winEn;

  vtg_regfile #(.ADDR_W(4), .DATA_W(32)) regs_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regWords(regWords)
  );

  assign winEn = regWords[IDX_WINH][EN_BIT] && regWords[IDX_WINV0][EN_BIT];

  vtg_ctrl #(.H_W(H_W), .F_W(F_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .runEn(regWords[IDX_RUN][0]),
    .lineLen(regWords[IDX_LINE][HI_LSB +: H_W]),
    .hPulse(regWords[IDX_LINE][H_W-1:0]),
    .skew(regWords[IDX_SKEW][H_W-1:0]),
    .frameLen(regWords[IDX_FRAME][F_W-1:0]),
    .vWidth(regWords[IDX_VWIDTH][F_W-1:0]),
    .dispHs(regWords[IDX_DISPH][H_W-1:0]),
    .dispHe(regWords[IDX_DISPH][HI_LSB +: H_W]),
    .dispVs(regWords[IDX_DISPV0][F_W-1:0]),
    .dispVe(regWords[IDX_DISPV1][F_W-1:0]),
    .winEn(winEn),
    .winHs(regWords[IDX_WINH][H_W-1:0]),
    .winHe(regWords[IDX_WINH][HI_LSB +: H_W]),
    .winVs(regWords[IDX_WINV0][F_W-1:0]),
    .winVe(regWords[IDX_WINV1][F_W-1:0]),
    .strb(strb)
  );

  assign pixReq = strb.pixReq;

  vtg_datapath #(.COLOR_W(COLOR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pixIn(pixIn), .pixValid(pixValid),
    .borderColor(regWords[IDX_BORDER][COLOR_W-1:0]),
    .uflColor(regWords[IDX_UFL][COLOR_W-1:0]),
    .recoverEn(regWords[IDX_UFL][EN_BIT]),
    .polBits(regWords[IDX_POL][2:0]),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pixOut(pixOut), .frameStart(frameStart)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int COLOR_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               runEn,
  input logic [2:0]         polBits,
  input logic [31:0]        frameLenWord,
  input logic [COLOR_W-1:0] uflColor,
  input logic               pixReq,
  input logic               pixValid,
  input logic               hsyncOut,
  input logic               vsyncOut,
  input logic               deOut,
  input logic [COLOR_W-1:0] pixOut,
  input logic               frameStart
);
  assert_idle_no_frame_R1: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !frameStart);

  assert_idle_levels_R10: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (hsyncOut == $past(polBits[0]) && vsyncOut == $past(polBits[1])
                && deOut == $past(polBits[2])));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && runEn && frameLenWord > 32'd2 && $stable(frameLenWord)) |=> !frameStart);

  assert_blank_black_R5: assert property (@(posedge clk) disable iff (!rstN)
    (deOut == $past(polBits[2])) |-> (pixOut == '0));

  assert_underflow_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && pixReq && !pixValid) |=> (pixOut == $past(uflColor)));

  assert_no_req_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !pixReq);
endmodule

bind vtg_top vtg_checker #(.COLOR_W(COLOR_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .runEn(regWords[vtg_pkg::IDX_RUN][0]),
  .polBits(regWords[vtg_pkg::IDX_POL][2:0]),
  .frameLenWord(regWords[vtg_pkg::IDX_FRAME]),
  .uflColor(regWords[vtg_pkg::IDX_UFL][COLOR_W-1:0]),
  .pixReq(pixReq), .pixValid(pixValid),
  .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
  .pixOut(pixOut), .frameStart(frameStart)
);

// File: tb/vtg_top_tb_top.sv
`timescale 1ns/1ps
module vtg_top_tb_top;
  localparam int COLOR_W = 24;
  localparam logic [23:0] SRC = 24'h123456;
  localparam logic [23:0] BRD = 24'h00AA55;
  localparam logic [23:0] UFL = 24'h0000FF;

  // {count[7:0], hs, vs, de, sel[1:0], fs}; sel 0 blank, 1 border, 2 source
  localparam int NVEC = 16;
  localparam logic [13:0] VEC [NVEC] = '{
    {8'd0,  1'b1, 1'b1, 1'b0, 2'd0, 1'b1},
    {8'd1,  1'b1, 1'b1, 1'b0, 2'd0, 1'b0},
    {8'd2,  1'b0, 1'b1, 1'b0, 2'd0, 1'b0},
    {8'd11, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0},
    {8'd23, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
    {8'd27, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
    {8'd28, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},
    {8'd33, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
    {8'd34, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0},
    {8'd36, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0},
    {8'd37, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
    {8'd45, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
    {8'd50, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0},
    {8'd55, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},
    {8'd69, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},
    {8'd70, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [COLOR_W-1:0] pixIn = SRC;
  logic pixValid = 1'b1;
  logic pixReq, hsyncOut, vsyncOut, deOut, frameStart;
  logic [COLOR_W-1:0] pixOut;

  int checks = 0;
  int fails = 0;
  int step = 0;

  always #10 clk = ~clk;

  vtg_top dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .pixIn(pixIn), .pixValid(pixValid),
    .pixReq(pixReq), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .deOut(deOut), .pixOut(pixOut), .frameStart(frameStart)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
    step = 0;
  endtask

  // advance so that the output for counter position n is visible
  task automatic goStep(input int s);
    while (step < s) begin
      @(negedge clk);
      step++;
    end
  endtask

  task automatic restart();
    wr(4'd0, 32'd0);
    @(negedge clk);
    wr(4'd0, 32'd1);
  endtask

  function automatic logic [23:0] selPix(input logic [1:0] s);
    return (s == 2'd1) ? BRD : (s == 2'd2) ? SRC : 24'h0;
  endfunction

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 idle syncs", {hsyncOut, vsyncOut, deOut}, 3'b000);
    check("R1 idle pixel", pixOut, 0);
    check("R1 idle frameStart/pixReq", {frameStart, pixReq}, 2'b00);

    wr(4'd3, {16'd10, 16'd2});
    wr(4'd4, 32'd70);
    wr(4'd5, 32'd10);
    wr(4'd6, {16'd7, 16'd3});
    wr(4'd7, 32'd20);
    wr(4'd8, 32'd50);
    wr(4'd9, {1'b1, 15'd6, 16'd4});
    wr(4'd10, 32'h8000_0000 | 32'd30);
    wr(4'd11, 32'd39);
    wr(4'd12, {8'h00, UFL});
    wr(4'd13, {8'h00, BRD});
    check("R1 still idle after setup", {hsyncOut, vsyncOut, deOut, frameStart}, 4'b0000);

    // R2 R3 R4 R5 R6 R11: table walk over one frame plus wrap
    wr(4'd0, 32'd1);
    for (int i = 0; i < NVEC; i++) begin
      goStep(int'(VEC[i][13:6]) + 1);
      check($sformatf("R2/R3/R4/R5/R6/R11 vec %0d", VEC[i][13:6]),
            {hsyncOut, vsyncOut, deOut, pixOut, frameStart},
            {VEC[i][5], VEC[i][4], VEC[i][3], selPix(VEC[i][2:1]), VEC[i][0]});
    end

    // R8: single starved pixel without recovery
    restart();
    goStep(34); pixValid = 1'b0;
    goStep(35); pixValid = 1'b1;
    check("R8 starved pixel", pixOut, UFL);
    goStep(36);
    check("R8 next pixel normal", pixOut, SRC);

    // R9: recovery holds underflow color until next frame
    wr(4'd12, {1'b1, 7'h0, UFL});
    restart();
    goStep(34); pixValid = 1'b0;
    goStep(35); pixValid = 1'b1;
    check("R9 starved pixel", pixOut, UFL);
    goStep(37);
    check("R9 held underflow", pixOut, UFL);
    goStep(38);
    check("R9 border unaffected", pixOut, BRD);
    goStep(105);
    check("R9 resumes next frame", pixOut, SRC);
    wr(4'd12, {8'h00, UFL});

    // R7: sub-window disabled -> whole display sourced
    wr(4'd9, {1'b0, 15'd6, 16'd4});
    restart();
    goStep(24);
    check("R7 former border now source", pixOut, SRC);
    goStep(34);
    check("R7 line edge source", pixOut, SRC);
    wr(4'd9, {1'b1, 15'd6, 16'd4});

    // R3: hsync skew
    wr(4'd2, 32'd3);
    restart();
    goStep(3);
    check("R3 skew before pulse", hsyncOut, 1'b0);
    goStep(4);
    check("R3 skew pulse start", hsyncOut, 1'b1);
    goStep(5);
    check("R3 skew pulse end", hsyncOut, 1'b1);
    goStep(6);
    check("R3 after skewed pulse", hsyncOut, 1'b0);
    wr(4'd2, 32'd0);

    // R10 and R1: polarity inverted, idle levels follow it
    wr(4'd1, 32'd7);
    wr(4'd0, 32'd0);
    @(negedge clk); @(negedge clk);
    check("R10 idle inverted levels", {hsyncOut, vsyncOut, deOut}, 3'b111);
    check("R1 disabled frameStart/pixel", {frameStart, pixOut}, 25'd0);
    wr(4'd0, 32'd1);
    goStep(1);
    check("R10 active-low syncs at frame start", {hsyncOut, vsyncOut, deOut, frameStart}, 4'b0011);
    goStep(35);
    check("R10 active-low data enable", {hsyncOut, vsyncOut, deOut, pixOut}, {3'b110, SRC});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule